// File: doc/BRIEF.md
# Bernoulli Cell Arrival Source

This block produces a slotted stream of cell arrivals for driving a discrete-time queue model. Each clock is one slot. In random mode a 127-bit linear feedback shift register, built on the trinomial x^127 + x + 1, is jumped sixteen positions per slot. The sixteen bits it passes over form a fresh unsigned word. A cell is announced when that word is below a programmable threshold, so the threshold sets the per-slot arrival probability at about threshold/65535. Successive gaps between arrivals are then geometrically distributed.

In periodic mode the same output instead carries a deterministic flow: a slot counter fires once every P slots, and every such cell is tagged as belonging to the point-to-point flow rather than the background traffic. The generator and the counter both keep running whichever mode is selected. An enable input freezes them, and a load strobe reseeds the generator from a port.

Top module: `geo_cell_source`

## Requirements
- R1: While `rst_n` is low and on the first slot after it, `cell_valid` and `cell_tag` are 0; reset puts the generator state at 127'h3A5C_96E1_0F7B_D248_1C6F_A359_E70B_4D2 and the slot counter at 0.
- R2: The generator state s[126:0] holds the sequence a[n..n+126] (s[i] = a[n+i]) with a[m+127] = a[m] XOR a[m+1]. The slot word has bit k = s[k] for k = 0..15. Each enabled slot advances the state by 16 sequence positions.
- R3: In random mode (`periodic_mode` = 0), an enabled slot drives `cell_valid` to 1 on the next clock exactly when the slot word, read as unsigned, is below `rate_thresh`; `cell_tag` is then 0.
- R4: A threshold of 0 never yields a cell. A threshold of 65535 yields a cell in every slot except one whose word is 16'hFFFF.
- R5: In periodic mode, an enabled slot whose counter value is 0 yields `cell_valid` = 1 and `cell_tag` = 1 on the next clock; every other slot yields neither. `cell_tag` is never 1 without `cell_valid`.
- R6: The counter counts 0..P-1 and then wraps to 0. P equals `period_sel`, except that a value of 0 selects the default of 4. A value of 1 fires every slot.
- R7: If the counter value is already at or above P-1 (after `period_sel` is lowered), the next enabled slot wraps it to 0.
- R8: With `src_en` low, no cell is produced, and the generator state and the counter hold their values.
- R9: `seed_load` high loads `seed_val` into the generator, or 127'h1 when `seed_val` is all zero, and clears the counter. It takes priority over `src_en`, and the following clock shows no cell.
- R10: Switching mode does not reset the generator or the counter, since both advance on every enabled slot in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 1 | Advance the source this slot |
| seed_load | input | 1 | Load `seed_val` into the generator, clear the counter |
| seed_val | input | 127 | Generator seed |
| periodic_mode | input | 1 | 0 selects random arrivals, 1 selects the periodic flow |
| rate_thresh | input | 16 | Arrival threshold (probability x 65535) |
| period_sel | input | 4 | Periodic interval in slots, 0 selects 4 |
| cell_valid | output | 1 | A cell arrives in this slot |
| cell_tag | output | 1 | 1 for the periodic flow, 0 for background traffic |

## Verification
The bench builds the block with its default parameters: a 127-bit register with a single tap at 1, 16-bit words, a 4-bit period field and a default period of 4. At this width a seed can place any chosen value in the first slot word, so the extreme words 16'hFFFF and 0 can be set against the extreme thresholds on purpose. The 4-bit period lets every period value from 0 to 15 be tried, including lowering the period while the counter sits high.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic {
    SRC_RANDOM   = 1'b0,
    SRC_PERIODIC = 1'b1
  } src_mode_e;

  localparam logic TAG_BACKGROUND = 1'b0;
  localparam logic TAG_FLOW       = 1'b1;
endpackage

// File: rtl/fs_lfsr_bank.sv
module fs_lfsr_bank #(
  parameter int LFSR_W = 127,
  parameter int WORD_W = 16,
  parameter int TAP    = 1,
  parameter logic [LFSR_W-1:0] DEF_SEED = 127'h3A5C_96E1_0F7B_D248_1C6F_A359_E70B_4D2,
  parameter logic [LFSR_W-1:0] ZERO_SUB = 127'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  output logic [WORD_W-1:0] word
);
  localparam int KEEP_W = LFSR_W - WORD_W;

  logic [LFSR_W-1:0] state_q;
  logic [WORD_W-1:0] fresh_bits;
  logic [LFSR_W-1:0] jumped;
  logic [LFSR_W-1:0] seed_fix;

  // each new sequence bit depends only on bits already in the window
  genvar j;
  generate
    for (j = 0; j < WORD_W; j++) begin : g_fb
      assign fresh_bits[j] = state_q[j] ^ state_q[j+TAP];
    end
  endgenerate

  assign jumped   = {fresh_bits, state_q[LFSR_W-1:WORD_W]};
  assign seed_fix = (seed == '0) ? ZERO_SUB : seed;
  assign word     = state_q[WORD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= DEF_SEED;
    else if (load) state_q <= seed_fix;
    else if (adv)  state_q <= jumped;
  end

  // R9
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R8
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(state_q));

  initial begin
    if (KEEP_W <= TAP) $error("word width too large for tap");
  end
endmodule

// File: rtl/fs_slot_timer.sv
module fs_slot_timer #(
  parameter int PER_W      = 4,
  parameter int DEF_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  logic [PER_W-1:0] period,
  output logic             fire
);
  localparam logic [PER_W-1:0] DEF_P = PER_W'(DEF_PERIOD);

  function automatic logic [PER_W-1:0] eff_period(input logic [PER_W-1:0] p);
    return (p == '0) ? DEF_P : p;
  endfunction

  function automatic logic [PER_W-1:0] next_count(input logic [PER_W-1:0] c,
                                                  input logic [PER_W-1:0] p);
    return (c >= p - 1'b1) ? '0 : c + 1'b1;
  endfunction

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] eff_per;

  assign eff_per = eff_period(period);
  assign fire    = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (adv) cnt_q <= next_count(cnt_q, eff_per);
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (cnt_q < $past(eff_per)));
  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/fs_arrival_pick.sv
module fs_arrival_pick
  import fs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  src_mode_e         mode,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] thresh,
  input  logic              fire,
  output logic              hit,
  output logic              tag
);
  always_comb begin
    if (mode == SRC_PERIODIC) begin
      hit = fire;
      tag = fire ? TAG_FLOW : TAG_BACKGROUND;
    end else begin
      hit = (word < thresh);
      tag = TAG_BACKGROUND;
    end
  end
endmodule

// File: rtl/geo_cell_source.sv
module geo_cell_source
  import fs_pkg::*;
#(
  parameter int LFSR_W     = 127,
  parameter int WORD_W     = 16,
  parameter int TAP        = 1,
  parameter int PER_W      = 4,
  parameter int DEF_PERIOD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_en,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_val,
  input  logic              periodic_mode,
  input  logic [WORD_W-1:0] rate_thresh,
  input  logic [PER_W-1:0]  period_sel,
  output logic              cell_valid,
  output logic              cell_tag
);
  logic [WORD_W-1:0] slot_word;
  logic              slot_fire;
  logic              slot_hit;
  logic              slot_tag;
  logic              slot_adv;
  src_mode_e         mode_sel;

  assign slot_adv = src_en && !seed_load;
  assign mode_sel = periodic_mode ? SRC_PERIODIC : SRC_RANDOM;

  fs_lfsr_bank #(.LFSR_W(LFSR_W), .WORD_W(WORD_W), .TAP(TAP)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(slot_adv), .load(seed_load),
    .seed(seed_val), .word(slot_word)
  );

  fs_slot_timer #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .adv(slot_adv), .clr(seed_load),
    .period(period_sel), .fire(slot_fire)
  );

  fs_arrival_pick #(.WORD_W(WORD_W)) u_pick (
    .mode(mode_sel), .word(slot_word), .thresh(rate_thresh),
    .fire(slot_fire), .hit(slot_hit), .tag(slot_tag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_valid <= 1'b0;
      cell_tag   <= 1'b0;
    end else begin
      cell_valid <= slot_adv && slot_hit;
      cell_tag   <= slot_adv && slot_tag;
    end
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |=> !cell_valid);
  // R4
  zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_adv && !periodic_mode && rate_thresh == '0) |=> !cell_valid);
  // R5
  tag_needs_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_tag |-> cell_valid);
  // R5
  periodic_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_adv && periodic_mode) |=> (cell_valid == cell_tag));
  // R9
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> !cell_valid);
endmodule

// File: tb/geo_cell_source_bench.sv
module geo_cell_source_bench;
  localparam logic [126:0] RST_SEED = 127'h3A5C_96E1_0F7B_D248_1C6F_A359_E70B_4D2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         src_en = 1'b0;
  logic         seed_load = 1'b0;
  logic [126:0] seed_val = '0;
  logic         periodic_mode = 1'b0;
  logic [15:0]  rate_thresh = '0;
  logic [3:0]   period_sel = '0;
  logic         cell_valid;
  logic         cell_tag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [126:0] m_s;
  int           m_cnt;
  bit           m_v;
  bit           m_t;

  always #5 clk = ~clk;

  geo_cell_source u_geo_cell_source (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .seed_load(seed_load),
    .seed_val(seed_val), .periodic_mode(periodic_mode),
    .rate_thresh(rate_thresh), .period_sel(period_sel),
    .cell_valid(cell_valid), .cell_tag(cell_tag)
  );

  // serial restatement: emit the oldest bit, append a[m]^a[m+1], sixteen times
  function automatic logic [15:0] pull_word(inout logic [126:0] s);
    logic [15:0] w;
    logic        nb;
    for (int k = 0; k < 16; k++) begin
      w[k] = s[0];
      nb   = s[0] ^ s[1];
      s    = {nb, s[126:1]};
    end
    return w;
  endfunction

  function automatic int period_of(input logic [3:0] p);
    return (p == 4'd0) ? 4 : int'(p);
  endfunction

  task automatic model_edge();
    logic [15:0] w;
    bit hit;
    int p;
    if (!rst_n) begin
      m_s = RST_SEED; m_cnt = 0; m_v = 0; m_t = 0;
    end else if (seed_load) begin
      m_s = (seed_val == '0) ? 127'h1 : seed_val;
      m_cnt = 0; m_v = 0; m_t = 0;
    end else if (src_en) begin
      w   = pull_word(m_s);
      p   = period_of(period_sel);
      hit = periodic_mode ? (m_cnt == 0) : (w < rate_thresh);
      m_v = hit;
      m_t = hit && periodic_mode;
      m_cnt = (m_cnt >= p - 1) ? 0 : m_cnt + 1;
    end else begin
      m_v = 0; m_t = 0;
    end
  endtask

  task automatic slot(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (cell_valid !== m_v || cell_tag !== m_t) begin
      fails++;
      $display("FAIL %s: valid/tag actual %b/%b expected %b/%b at %0t",
               req, cell_valid, cell_tag, m_v, m_t, $time);
    end
  endtask

  function automatic logic [126:0] rnd_seed();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 reset state
    for (int i = 0; i < 3; i++) slot("R1");
    @(negedge clk); rst_n = 1'b1;
    src_en = 1'b1; rate_thresh = 16'd52429;
    for (int i = 0; i < 40; i++) slot("R1 R2");

    // R3 random thresholds
    for (int i = 0; i < 400; i++) begin
      rate_thresh = 16'($urandom);
      slot("R3");
    end
    // R4 extreme thresholds
    rate_thresh = 16'd0;
    for (int i = 0; i < 60; i++) slot("R4");
    rate_thresh = 16'hFFFF;
    for (int i = 0; i < 60; i++) slot("R4");

    // R4 directed word 16'hFFFF against threshold 65535
    seed_load = 1'b1; seed_val = {rnd_seed() >> 16, 16'hFFFF};
    slot("R9");
    seed_load = 1'b0;
    slot("R4");
    // word 0 against threshold 1
    seed_load = 1'b1; seed_val = {rnd_seed() >> 16, 16'h0000};
    slot("R9");
    seed_load = 1'b0; rate_thresh = 16'd1;
    slot("R4");

    // R9 zero seed substituted; also load wins over disabled state
    seed_load = 1'b1; seed_val = '0; src_en = 1'b0;
    slot("R9");
    seed_load = 1'b0; src_en = 1'b1;
    for (int i = 0; i < 100; i++) begin
      rate_thresh = 16'($urandom);
      slot("R9 R2");
    end

    // R5 periodic default interval 4
    periodic_mode = 1'b1; period_sel = 4'd4;
    for (int i = 0; i < 40; i++) slot("R5");
    // R6 period 0 and 1
    period_sel = 4'd0;
    for (int i = 0; i < 24; i++) slot("R6");
    period_sel = 4'd1;
    for (int i = 0; i < 12; i++) slot("R6");
    for (int i = 0; i < 120; i++) begin
      if (i % 20 == 0) period_sel = 4'($urandom);
      slot("R5");
    end
    // R7 lower period while counter is high
    period_sel = 4'd15;
    for (int i = 0; i < 12; i++) slot("R7");
    period_sel = 4'd2;
    for (int i = 0; i < 8; i++) slot("R7");

    // R8 enable toggling, R10 mode toggling
    for (int i = 0; i < 600; i++) begin
      src_en        = ($urandom % 4) != 0;
      periodic_mode = ($urandom % 5) == 0;
      rate_thresh   = 16'($urandom);
      if (i % 50 == 0) period_sel = 4'($urandom);
      slot((i % 2 == 0) ? "R8" : "R10");
    end

    // R9 loads mixed with enables
    for (int i = 0; i < 200; i++) begin
      seed_load     = ($urandom % 16) == 0;
      seed_val      = rnd_seed();
      src_en        = ($urandom % 3) != 0;
      periodic_mode = ($urandom % 3) == 0;
      rate_thresh   = 16'($urandom);
      slot("R9");
    end
    seed_load = 1'b0;

    // R1 reset during activity
    rst_n = 1'b0;
    slot("R1");
    @(negedge clk); rst_n = 1'b1; periodic_mode = 1'b0; src_en = 1'b1;
    for (int i = 0; i < 30; i++) begin
      rate_thresh = 16'($urandom);
      slot("R1 R3");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule